// File: doc/BRIEF.md
# Programmable Cascadable Interrupt Controller

This block collects eight interrupt request lines, ranks them by a rotating priority and raises one interrupt output toward a processor. Software programs it through a byte-wide register port. The command address takes a start-of-setup byte and the run-time commands. The data address takes the remaining setup bytes and, once setup is over, the mask. A setup pass fixes the trigger mode, single or cascaded operation, the upper bits of the returned vector, which lines lead to a slave controller, and whether end-of-interrupt happens on its own.

When the processor pulses the acknowledge input, the controller picks the winning unmasked request, clears its request bit and marks it in service. With automatic end-of-interrupt enabled, the line is retired at once instead. One cycle later the controller presents an 8-bit vector. If the winning line is wired to a slave, it pulses a cascade acknowledge and forwards the byte that the slave returns. Run-time commands retire in-service lines, either the top-ranked one or a named one, and rotate or set the priority order.

The register port is a valid/ready stream. Ready is always high, so a byte is accepted in every cycle that valid is high and there is no back-pressure. The vector leaves as a one-cycle valid pulse with no ready. The caller must take it in that cycle.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are zero, the priority base is line 0 (line 7 ranks highest), automatic end-of-interrupt and its rotate flag are off, and the setup sequence is idle. `int_out`, `vec_valid` and `casc_ack` are low and `cfg_ready` is high.
- R2: A byte written to address 0 with bit 4 set starts setup and clears the mask. In that byte, bit 3 = 1 selects edge triggering (0 selects level), bit 1 = 1 selects single operation (0 selects cascade), and bit 0 = 1 requests a mode byte.
- R3: Setup then takes the next writes to address 1 in this order: a base byte (bits 7:3 become vector bits 7:3), a slave-line map (bit n marks line n), and the mode byte only if it was requested. Without a mode byte, automatic end-of-interrupt is forced off. After setup, address-1 writes load the mask (bit n = 1 masks line n).
- R4: In edge mode a request bit is set by a rising input and stays set until acknowledged, even while the input stays high. In level mode the request bit follows the input each cycle.
- R5: Masked lines never take part in selection. `int_out` is high only when an unmasked request outranks every in-service line.
- R6: An acknowledge selects the top-ranked unmasked request, clears its request bit and presents `{base, line}` with `vec_valid` high on the following cycle. With no eligible request it presents `{base, 3'b111}` and changes no state.
- R7: Without automatic end-of-interrupt, the acknowledged line's in-service bit is set, and this blocks `int_out` for equal and lower-ranked requests.
- R8: In the mode byte, bit 1 = 1 enables automatic end-of-interrupt: acknowledged lines are never marked in service. Bits 3:2 and bit 0 have no effect.
- R9: An address-0 command with bits 4:3 = 00 uses bits 7:5 as its code. Code 001 retires the top-ranked in-service line, and code 011 retires the line named in bits 2:0.
- R10: Code 101 retires the top-ranked in-service line and makes it lowest priority. Code 111 retires line bits 2:0 and makes it lowest. Code 110 makes line bits 2:0 lowest without retiring anything.
- R11: Code 100 sets the rotate-on-automatic-EOI flag and code 000 clears it. While the flag and automatic end-of-interrupt are both on, each acknowledged line becomes lowest priority.
- R12: In cascade mode an acknowledge whose winning line is set in the slave map pulses `casc_ack` for one cycle with no vector. The controller then waits, ignoring acknowledges, and presents the slave's byte on the cycle after `casc_vec_valid`. In single mode `casc_ack` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request inputs |
| cfg_valid | input | 1 | Register write valid |
| cfg_ready | output | 1 | Register write ready (always high) |
| cfg_addr | input | 1 | 0 = command address, 1 = data address |
| cfg_data | input | 8 | Register write byte |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge strobe from the processor |
| vec_valid | output | 1 | Vector valid pulse |
| vec_data | output | 8 | Vector byte |
| casc_ack | output | 1 | Acknowledge pulse to the slave controller |
| casc_vec_valid | input | 1 | Slave vector valid |
| casc_vec | input | 8 | Slave vector byte |

## Verification
A corrupted request, mask or in-service bit shows on `int_out` in the cycle after the corruption, because that output is decoded directly from those registers. A wrong priority base or setup state stays hidden until the next acknowledge. It then surfaces as a wrong vector one cycle after the strobe, or as a cascade pulse where a vector was due. The directed scenarios therefore pair every state change with an acknowledge or an `int_out` sample chosen so that the two outcomes differ. Examples are two simultaneous requests whose order flips under rotation, and a held level input that re-requests a line still in service.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int VEC_W = 8;
  localparam int BASE_W = VEC_W - IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_MAP  = 2'd2,
    ST_MODE = 2'd3
  } setup_st_e;

  typedef enum logic [2:0] {
    OP_ROT_AEOI_CLR = 3'b000,
    OP_EOI_NS       = 3'b001,
    OP_NOP          = 3'b010,
    OP_EOI_SP       = 3'b011,
    OP_ROT_AEOI_SET = 3'b100,
    OP_ROT_EOI_NS   = 3'b101,
    OP_SET_PRIO     = 3'b110,
    OP_ROT_EOI_SP   = 3'b111
  } op_e;

  typedef struct packed {
    logic              edge_mode;
    logic              single;
    logic              aeoi;
    logic              rot_aeoi;
    logic [BASE_W-1:0] base;
    logic [LINES-1:0]  slave_map;
    logic [LINES-1:0]  mask;
  } cfg_t;
endpackage

// File: rtl/pic8_prio.sv
module pic8_prio
  import pic8_pkg::*;
(
  input  logic [LINES-1:0] req,
  input  logic [IDX_W-1:0] bottom,
  output logic             any,
  output logic [IDX_W-1:0] win,
  output logic [IDX_W-1:0] rank
);
  // Scan upward in rank from the lowest-priority line; the last hit wins.
  always_comb begin
    win  = bottom;
    rank = '0;
    for (int k = 0; k < LINES; k++) begin
      if (req[bottom + IDX_W'(k)]) begin
        win  = bottom + IDX_W'(k);
        rank = IDX_W'(k);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/pic8_cmd.sv
module pic8_cmd
  import pic8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [VEC_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic             op_stb,
  output op_e              op_code,
  output logic [IDX_W-1:0] op_lvl
);
  setup_st_e         st_q;
  logic              need_mode_q;
  logic              edge_q, single_q, aeoi_q, rot_q;
  logic [BASE_W-1:0] base_q;
  logic [LINES-1:0]  map_q, mask_q;
  logic              start_wr;

  assign start_wr = wr_en && !wr_addr && wr_data[4];
  // Run-time commands are only decoded outside setup.
  assign op_stb  = wr_en && !wr_addr && !wr_data[4] && !wr_data[3] && (st_q == ST_IDLE);
  assign op_code = op_e'(wr_data[7:5]);
  assign op_lvl  = wr_data[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      need_mode_q <= 1'b0;
      edge_q      <= 1'b1;
      single_q    <= 1'b1;
      aeoi_q      <= 1'b0;
      rot_q       <= 1'b0;
      base_q      <= '0;
      map_q       <= '0;
      mask_q      <= '0;
    end else if (start_wr) begin
      mask_q      <= '0;
      edge_q      <= wr_data[3];
      single_q    <= wr_data[1];
      need_mode_q <= wr_data[0];
      if (!wr_data[0]) aeoi_q <= 1'b0;
      st_q        <= ST_BASE;
    end else if (wr_en && wr_addr) begin
      case (st_q)
        ST_IDLE: mask_q <= wr_data[LINES-1:0];
        ST_BASE: begin
          base_q <= wr_data[VEC_W-1:IDX_W];
          st_q   <= ST_MAP;
        end
        ST_MAP: begin
          map_q <= wr_data[LINES-1:0];
          st_q  <= need_mode_q ? ST_MODE : ST_IDLE;
        end
        default: begin
          aeoi_q <= wr_data[1];
          st_q   <= ST_IDLE;
        end
      endcase
    end else if (op_stb) begin
      if (op_code == OP_ROT_AEOI_CLR) rot_q <= 1'b0;
      if (op_code == OP_ROT_AEOI_SET) rot_q <= 1'b1;
    end
  end

  always_comb begin
    cfg.edge_mode = edge_q;
    cfg.single    = single_q;
    cfg.aeoi      = aeoi_q;
    cfg.rot_aeoi  = rot_q;
    cfg.base      = base_q;
    cfg.slave_map = map_q;
    cfg.mask      = mask_q;
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter bit HAS_SLAVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_addr,
  input  logic [VEC_W-1:0] cfg_data,
  output logic             int_out,
  input  logic             ack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data,
  output logic             casc_ack,
  input  logic             casc_vec_valid,
  input  logic [VEC_W-1:0] casc_vec
);
  cfg_t             cfg_q;
  logic             op_stb;
  op_e              op_code;
  logic [IDX_W-1:0] op_lvl;
  logic             wr_en;

  assign cfg_ready = 1'b1;
  assign wr_en     = cfg_valid && cfg_ready;

  pic8_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .cfg     (cfg_q),
    .op_stb  (op_stb),
    .op_code (op_code),
    .op_lvl  (op_lvl)
  );

  logic [LINES-1:0] mask_q;
  logic             aeoi_q, single_q, edge_q;
  assign mask_q   = cfg_q.mask;
  assign aeoi_q   = cfg_q.aeoi;
  assign single_q = cfg_q.single;
  assign edge_q   = cfg_q.edge_mode;

  logic [LINES-1:0] irq_q, irr, isr, irr_nx, isr_nx, eligible, ack_sel, isr_clr;
  logic [IDX_W-1:0] bottom, bottom_nx;
  logic             req_any, isr_any;
  logic [IDX_W-1:0] req_win, req_rank, isr_win, isr_rank;
  logic             waiting, ack_take, ack_hit, to_slave;
  logic [VEC_W-1:0] local_vec;

  assign eligible = irr & ~mask_q;

  pic8_prio u_req_prio (
    .req    (eligible),
    .bottom (bottom),
    .any    (req_any),
    .win    (req_win),
    .rank   (req_rank)
  );

  pic8_prio u_isr_prio (
    .req    (isr),
    .bottom (bottom),
    .any    (isr_any),
    .win    (isr_win),
    .rank   (isr_rank)
  );

  assign int_out  = req_any && (!isr_any || (req_rank > isr_rank));
  assign ack_take = ack && !waiting;
  assign ack_hit  = ack_take && req_any;
  assign to_slave = ack_hit && HAS_SLAVE && !single_q && cfg_q.slave_map[req_win];
  assign ack_sel  = ack_hit ? (LINES'(1) << req_win) : '0;
  assign local_vec = req_any ? {cfg_q.base, req_win} : {cfg_q.base, {IDX_W{1'b1}}};

  // Per-line request capture, edge or level.
  for (genvar g = 0; g < LINES; g++) begin : g_req
    assign irr_nx[g] = edge_q ? ((irr[g] & ~ack_sel[g]) | (irq_in[g] & ~irq_q[g]))
                              : irq_in[g];
  end

  always_comb begin
    isr_clr   = '0;
    bottom_nx = bottom;
    if (ack_hit && aeoi_q && cfg_q.rot_aeoi) bottom_nx = req_win;
    if (op_stb) begin
      case (op_code)
        OP_EOI_NS, OP_ROT_EOI_NS: begin
          if (isr_any) begin
            isr_clr = LINES'(1) << isr_win;
            if (op_code == OP_ROT_EOI_NS) bottom_nx = isr_win;
          end
        end
        OP_EOI_SP, OP_ROT_EOI_SP: begin
          isr_clr = LINES'(1) << op_lvl;
          if (op_code == OP_ROT_EOI_SP) bottom_nx = op_lvl;
        end
        OP_SET_PRIO: bottom_nx = op_lvl;
        default: ;
      endcase
    end
    isr_nx = (isr | (aeoi_q ? '0 : ack_sel)) & ~isr_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      irr       <= '0;
      isr       <= '0;
      bottom    <= '0;
      waiting   <= 1'b0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
      casc_ack  <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      irr       <= irr_nx;
      isr       <= isr_nx;
      bottom    <= bottom_nx;
      vec_valid <= 1'b0;
      casc_ack  <= 1'b0;
      if (ack_take) begin
        if (to_slave) begin
          casc_ack <= 1'b1;
          waiting  <= 1'b1;
        end else begin
          vec_valid <= 1'b1;
          vec_data  <= local_vec;
        end
      end else if (waiting && casc_vec_valid) begin
        vec_valid <= 1'b1;
        vec_data  <= casc_vec;
        waiting   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_addr,
  input logic             cfg_b4,
  input logic [LINES-1:0] irq_in,
  input logic             ack,
  input logic             int_out,
  input logic             vec_valid,
  input logic             casc_ack,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] irr,
  input logic [LINES-1:0] isr,
  input logic             waiting,
  input logic             req_any,
  input logic             aeoi,
  input logic             single,
  input logic             edge_mode
);
  a_r2_start_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_addr && cfg_b4) |=> (mask == '0));

  a_r5_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  a_r4_level_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !cfg_valid) |=> (irr == $past(irq_in)));

  a_r7_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !waiting && req_any && !aeoi && !cfg_valid) |=> (isr != '0));

  a_r8_auto_eoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && !cfg_valid) |=> $stable(isr));

  a_r12_casc_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
    casc_ack |-> !vec_valid);

  a_r12_single_no_casc: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !$past(cfg_valid)) |-> !casc_ack);
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_addr  (cfg_addr),
  .cfg_b4    (cfg_data[4]),
  .irq_in    (irq_in),
  .ack       (ack),
  .int_out   (int_out),
  .vec_valid (vec_valid),
  .casc_ack  (casc_ack),
  .mask      (mask_q),
  .irr       (irr),
  .isr       (isr),
  .waiting   (waiting),
  .req_any   (req_any),
  .aeoi      (aeoi_q),
  .single    (single_q),
  .edge_mode (edge_q)
);

// File: tb/pic8_ctrl_tb.sv
`timescale 1ns/1ps
module pic8_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_valid = 1'b0, cfg_addr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       cfg_ready, int_out, ack = 1'b0, vec_valid, casc_ack;
  logic [7:0] vec_data;
  logic       casc_vec_valid = 1'b0;
  logic [7:0] casc_vec = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pic8_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .int_out(int_out), .ack(ack), .vec_valid(vec_valid), .vec_data(vec_data),
    .casc_ack(casc_ack), .casc_vec_valid(casc_vec_valid), .casc_vec(casc_vec)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cfg_valid = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk); cfg_valid = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic ack_expect(input string what, input logic [7:0] exp);
    pulse_ack();
    chk({what, " vec_valid"}, vec_valid, 1'b1);
    chk({what, " vector"}, vec_data, exp);
    chk({what, " no cascade"}, casc_ack, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 int_out low", int_out, 1'b0);
    chk("R1 vec_valid low", vec_valid, 1'b0);
    chk("R1 casc_ack low", casc_ack, 1'b0);
    chk("R1 ready high", cfg_ready, 1'b1);
  endtask

  task automatic t_basic();
    wr(0, 8'h1B); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h01);
    set_irq(8'h08);
    chk("R4 edge request raises int", int_out, 1'b1);
    ack_expect("R6 line3", 8'h43);
    chk("R6 request cleared", int_out, 1'b0);
    set_irq(8'h0A);
    chk("R7 lower line blocked by service", int_out, 1'b0);
    set_irq(8'h2A);
    chk("R5 higher line outranks service", int_out, 1'b1);
    ack_expect("R6 line5", 8'h45);
    wr(0, 8'h20);
    chk("R9 nonspecific EOI retires line5 only", int_out, 1'b0);
    wr(0, 8'h63);
    chk("R9 specific EOI line3", int_out, 1'b1);
    ack_expect("R6 line1", 8'h41);
    wr(0, 8'h20);
    chk("R4 held edge input no re-request", int_out, 1'b0);
    set_irq(8'h00);
  endtask

  task automatic t_mask();
    wr(1, 8'h10);
    set_irq(8'h10);
    chk("R5 masked line silent", int_out, 1'b0);
    set_irq(8'h14);
    chk("R5 unmasked line raises", int_out, 1'b1);
    ack_expect("R5 masked line skipped", 8'h42);
    wr(0, 8'h20);
    wr(1, 8'h00);
    chk("R5 unmask exposes latched request", int_out, 1'b1);
    ack_expect("R5 line4 after unmask", 8'h44);
    wr(0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_spurious();
    ack_expect("R6 no request default vector", 8'h47);
    chk("R6 spurious leaves int low", int_out, 1'b0);
  endtask

  task automatic t_aeoi();
    wr(0, 8'h1B); wr(1, 8'h80); wr(1, 8'h00); wr(1, 8'h0F);
    set_irq(8'h40);
    ack_expect("R8 line6", 8'h86);
    set_irq(8'h44);
    chk("R8 no service mark, lower line raises", int_out, 1'b1);
    ack_expect("R8 line2", 8'h82);
    set_irq(8'h00);
  endtask

  task automatic t_rot_aeoi();
    wr(0, 8'h80);
    set_irq(8'h08);
    ack_expect("R11 line3", 8'h83);
    set_irq(8'h1C);
    ack_expect("R11 rotated order picks line2", 8'h82);
    ack_expect("R11 then line4", 8'h84);
    wr(0, 8'h00); wr(0, 8'hC0);
    set_irq(8'h00);
    set_irq(8'h40);
    ack_expect("R11 line6 no rotate", 8'h86);
    set_irq(8'hE0);
    ack_expect("R11 flag cleared keeps order", 8'h87);
    ack_expect("R11 then line5", 8'h85);
    set_irq(8'h00);
  endtask

  task automatic t_level();
    wr(0, 8'h12); wr(1, 8'h60); wr(1, 8'h00); wr(1, 8'h04);
    set_irq(8'h04);
    chk("R3 third data byte is mask", int_out, 1'b0);
    wr(1, 8'h00);
    chk("R4 level request", int_out, 1'b1);
    ack_expect("R3 level line2", 8'h62);
    chk("R3 auto EOI forced off, service blocks", int_out, 1'b0);
    wr(0, 8'h20);
    chk("R9 EOI reopens held level", int_out, 1'b1);
    set_irq(8'h00);
    chk("R4 level drop clears request", int_out, 1'b0);
  endtask

  task automatic t_rotate();
    wr(0, 8'h1B); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h01);
    wr(0, 8'hC5);
    set_irq(8'h50);
    ack_expect("R10 set priority picks line4", 8'h04);
    set_irq(8'h58);
    chk("R10 line3 below in-service line4", int_out, 1'b0);
    wr(0, 8'hA0);
    ack_expect("R10 rotate nonspecific picks line3", 8'h03);
    wr(0, 8'hE3);
    ack_expect("R10 line6", 8'h06);
    wr(0, 8'h20);
    set_irq(8'h00);
    set_irq(8'h14);
    ack_expect("R10 rotate specific picks line2", 8'h02);
    wr(0, 8'h20);
    ack_expect("R10 then line4", 8'h04);
    wr(0, 8'h20);
    wr(0, 8'hC0);
    set_irq(8'h00);
  endtask

  task automatic t_cascade();
    wr(0, 8'h19); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    set_irq(8'h04);
    pulse_ack();
    chk("R12 cascade pulse", casc_ack, 1'b1);
    chk("R12 no local vector", vec_valid, 1'b0);
    set_irq(8'h24);
    pulse_ack();
    chk("R12 ack ignored while waiting casc", casc_ack, 1'b0);
    chk("R12 ack ignored while waiting vec", vec_valid, 1'b0);
    @(negedge clk); casc_vec_valid = 1'b1; casc_vec = 8'h9A;
    @(negedge clk); casc_vec_valid = 1'b0;
    chk("R12 slave vector valid", vec_valid, 1'b1);
    chk("R12 slave vector forwarded", vec_data, 8'h9A);
    chk("R12 line5 still pending", int_out, 1'b1);
    ack_expect("R12 local line5", 8'h25);
    wr(0, 8'h20); wr(0, 8'h20);
    set_irq(8'h00);
    chk("R9 all retired", int_out, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_spurious();
    t_aeoi();
    t_rot_aeoi();
    t_level();
    t_rotate();
    t_cascade();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule